// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block produces the per-cycle control word of a small bus-oriented processor. Each cycle it reads a constant control store at an index made of the status flag (top bit), the four-bit opcode held in the instruction register (middle bits) and the current step number (low three bits). The word it returns carries one bit per datapath enable: bus drivers, register loads, an ALU subtract select, a memory write, a program-counter load, a halt request and an end-of-instruction marker. A three-bit step counter walks through the steps of the current instruction. It restarts at step 0 after any word that carries the end marker and freezes while the halt bit is present.

Every instruction starts with the same two fetch steps. The steps that follow are specific to the opcode. Because the flag is part of the store index, the conditional branch runs different microcode for the same opcode depending on the flag. Opcodes with no microcode behave as no-operation instructions. The word is a pure combinational function of the inputs and the step count, so the datapath can use it during the same cycle.

Top module: `ucode_seq`

## Requirements
- R1: While rst_n is low, tstate is 0 and ctrl_word equals the first fetch word (bits 0 and 1 set, all others clear).
- R2: Control word bits are: 0 pc_drive, 1 addr_load, 2 pc_step, 3 mem_drive, 4 ir_load, 5 ir_drive, 6 acc_load, 7 opb_load, 8 alu_drive, 9 alu_sub, 10 acc_drive, 11 mem_write, 12 pc_load, 13 out_load, 14 halt, 15 end. For every opcode and flag, step 0 gives bits {0,1} and step 1 gives bits {2,3,4}, with bit 15 added at step 1 when the instruction is fetch-only.
- R3: When the current word has neither halt nor end, tstate increases by one at the next clock edge.
- R4: After a word with the end bit, tstate is 0 in the next cycle.
- R5: A word with the halt bit and no end bit holds tstate, and therefore the word, unchanged until reset.
- R6: Opcodes are 0 nop, 1 load, 2 store, 3 add, 4 sub, 5 load-immediate, 6 jump, 7 output, 8 branch-if-not-zero, 15 halt. The number of steps up to and including the end word is: nop 2, load and store 4, add and sub 5, load-immediate, jump and output 3. Halt reaches step 2 and never ends.
- R7: Add: step 2 {5,1}, step 3 {3,7}, step 4 {8,6,15}. Sub: step 2 {5,1}, step 3 {3,7,9}, step 4 {8,9,6,15}.
- R8: Load: step 2 {5,1}, step 3 {3,6,15}. Store: step 2 {5,1}, step 3 {10,11,15}. Load-immediate step 2 {5,6,15}. Jump step 2 {5,12,15}. Output step 2 {10,13,15}.
- R9: The store index is {flag, opcode, tstate}. For branch-if-not-zero, flag 0 gives step 2 {5,12,15}, and flag 1 ends the instruction at step 1.
- R10: Opcodes 9 to 14 act as nop. Every entry that lies past an instruction's end holds only bit 15.
- R11: For every opcode except 8, the flag has no effect on the word.
- R12: At most one of the bus-driver bits 0, 3, 5, 8 and 10 is set in any word.
- R13: A change of opcode or flag changes ctrl_word within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPC_W (4) | Opcode from the instruction register |
| flag | input | 1 | Status flag from the status register |
| ctrl_word | output | CW_W (16) | Control word for the current step |
| tstate | output | TS_W (3) | Current step number |

## Verification
The hardest situations to reach from the ports are the store entries that no normal instruction visits: the halt freeze, the fetch-only branch taken with flag 1, and the filler entries past an instruction's end. The bench sweeps every opcode under both flag values from reset. It follows each instruction for nine cycles, so a halted instruction is seen holding and the end and restart of every other instruction are observed. To show that the word is combinational, the bench switches the opcode and the flag in the middle of a step with the clock stopped.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

   localparam int OPC_W = 4;
   localparam int TS_W  = 3;
   localparam int AW    = 1 + OPC_W + TS_W;
   localparam int DEPTH = 1 << AW;
   localparam int CW_W  = 16;

   // control word bit positions
   localparam int CB_PC_DRV  = 0;
   localparam int CB_ADDR_LD = 1;
   localparam int CB_PC_STEP = 2;
   localparam int CB_MEM_DRV = 3;
   localparam int CB_IR_LD   = 4;
   localparam int CB_IR_DRV  = 5;
   localparam int CB_ACC_LD  = 6;
   localparam int CB_OPB_LD  = 7;
   localparam int CB_ALU_DRV = 8;
   localparam int CB_ALU_SUB = 9;
   localparam int CB_ACC_DRV = 10;
   localparam int CB_MEM_WR  = 11;
   localparam int CB_PC_LD   = 12;
   localparam int CB_OUT_LD  = 13;
   localparam int CB_HALT    = 14;
   localparam int CB_END     = 15;

   typedef logic [CW_W-1:0] cword_t;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP = 4'h0,
      OP_LDM = 4'h1,
      OP_STM = 4'h2,
      OP_ADD = 4'h3,
      OP_SUB = 4'h4,
      OP_LDI = 4'h5,
      OP_JMP = 4'h6,
      OP_OUT = 4'h7,
      OP_BNZ = 4'h8,
      OP_HLT = 4'hF
   } opc_e;

   function automatic cword_t bitw(input int b);
      cword_t w;
      w    = '0;
      w[b] = 1'b1;
      return w;
   endfunction

   localparam cword_t W_FETCH_A = bitw(CB_PC_DRV) | bitw(CB_ADDR_LD);
   localparam cword_t W_FETCH_B = bitw(CB_PC_STEP) | bitw(CB_MEM_DRV) | bitw(CB_IR_LD);
   localparam cword_t W_END     = bitw(CB_END);
   localparam cword_t W_OPADDR  = bitw(CB_IR_DRV) | bitw(CB_ADDR_LD);

   // true when the instruction continues past the two fetch steps
   function automatic logic op_has_exec(input logic flg, input logic [OPC_W-1:0] opc);
      logic r;
      case (opc)
         OP_LDM, OP_STM, OP_ADD, OP_SUB,
         OP_LDI, OP_JMP, OP_OUT, OP_HLT: r = 1'b1;
         OP_BNZ:                         r = ~flg;
         default:                        r = 1'b0;
      endcase
      return r;
   endfunction

   // execute-phase word for steps 2 and above
   function automatic cword_t exec_word(input logic flg, input logic [OPC_W-1:0] opc,
                                        input logic [TS_W-1:0] ts);
      cword_t w;
      w = W_END;
      case (opc)
         OP_LDM: begin
            if (ts == 3'd2)      w = W_OPADDR;
            else if (ts == 3'd3) w = bitw(CB_MEM_DRV) | bitw(CB_ACC_LD) | W_END;
         end
         OP_STM: begin
            if (ts == 3'd2)      w = W_OPADDR;
            else if (ts == 3'd3) w = bitw(CB_ACC_DRV) | bitw(CB_MEM_WR) | W_END;
         end
         OP_ADD, OP_SUB: begin
            if (ts == 3'd2)      w = W_OPADDR;
            else if (ts == 3'd3) w = bitw(CB_MEM_DRV) | bitw(CB_OPB_LD);
            else if (ts == 3'd4) w = bitw(CB_ALU_DRV) | bitw(CB_ACC_LD) | W_END;
            if (opc == OP_SUB && (ts == 3'd3 || ts == 3'd4))
               w = w | bitw(CB_ALU_SUB);
         end
         OP_LDI: if (ts == 3'd2) w = bitw(CB_IR_DRV) | bitw(CB_ACC_LD) | W_END;
         OP_JMP: if (ts == 3'd2) w = bitw(CB_IR_DRV) | bitw(CB_PC_LD) | W_END;
         OP_OUT: if (ts == 3'd2) w = bitw(CB_ACC_DRV) | bitw(CB_OUT_LD) | W_END;
         OP_BNZ: if (ts == 3'd2 && !flg) w = bitw(CB_IR_DRV) | bitw(CB_PC_LD) | W_END;
         OP_HLT: if (ts == 3'd2) w = bitw(CB_HALT);
         default: w = W_END;
      endcase
      return w;
   endfunction

   function automatic cword_t ucode_entry(input logic flg, input logic [OPC_W-1:0] opc,
                                          input logic [TS_W-1:0] ts);
      cword_t w;
      if (ts == 3'd0)
         w = W_FETCH_A;
      else if (ts == 3'd1)
         w = op_has_exec(flg, opc) ? W_FETCH_B : (W_FETCH_B | W_END);
      else
         w = exec_word(flg, opc, ts);
      return w;
   endfunction

endpackage

// File: rtl/ucs_addr.sv
module ucs_addr #(
   parameter int OPC_W = 4,
   parameter int TS_W  = 3,
   localparam int AW   = 1 + OPC_W + TS_W
) (
   input  logic              flag,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [TS_W-1:0]   tstate,
   output logic [AW-1:0]     addr
);
   // flag on top so conditional opcodes own two separate pages
   assign addr = {flag, opcode, tstate};
endmodule

// File: rtl/ucs_rom.sv
module ucs_rom #(
   parameter int OPC_W     = 4,
   parameter int TS_W      = 3,
   parameter int CW_W      = 16,
   parameter int ROM_STYLE = 0,
   localparam int AW       = 1 + OPC_W + TS_W,
   localparam int DEPTH    = 1 << AW
) (
   input  logic [AW-1:0]   addr,
   output logic [CW_W-1:0] word
);
   import ucs_pkg::*;

   generate
      if (ROM_STYLE == 0) begin : g_table
         // constant table filled at elaboration
         logic [CW_W-1:0] tbl [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            localparam logic [AW-1:0] IDX = AW'(i);
            assign tbl[i] = ucode_entry(IDX[AW-1], IDX[AW-2 -: OPC_W], IDX[TS_W-1:0]);
         end
         assign word = tbl[addr];
      end else begin : g_logic
         // decoded directly as sum-of-products logic
         always_comb begin
            word = ucode_entry(addr[AW-1], addr[AW-2 -: OPC_W], addr[TS_W-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/ucs_tcount.sv
module ucs_tcount #(
   parameter int TS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            end_bit,
   input  logic            halt_bit,
   output logic [TS_W-1:0] tstate
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tstate <= '0;
      else if (end_bit)
         tstate <= '0;
      else if (!halt_bit)
         tstate <= tstate + 1'b1;
   end

   // R4: end marker restarts the step count
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      end_bit |=> (tstate == '0));

   // R3: plain words advance the step count by one
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_bit && !halt_bit) |=> (tstate == $past(tstate) + 1'b1));

   // R5: halt freezes the step count
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_bit && !end_bit) |=> $stable(tstate));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq #(
   parameter int OPC_W     = 4,
   parameter int TS_W      = 3,
   parameter int CW_W      = 16,
   parameter int ROM_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic             flag,
   output logic [CW_W-1:0]  ctrl_word,
   output logic [TS_W-1:0]  tstate
);
   import ucs_pkg::*;

   localparam int AW = 1 + OPC_W + TS_W;

   generate
      if (OPC_W != ucs_pkg::OPC_W) begin : g_bad_opc
         $error("ucode_seq: OPC_W must match the microcode opcode width");
      end
      if (TS_W != ucs_pkg::TS_W) begin : g_bad_ts
         $error("ucode_seq: TS_W must match the microcode step width");
      end
      if (CW_W != ucs_pkg::CW_W) begin : g_bad_cw
         $error("ucode_seq: CW_W must match the control word width");
      end
      if (ROM_STYLE < 0 || ROM_STYLE > 1) begin : g_bad_style
         $error("ucode_seq: ROM_STYLE must be 0 (table) or 1 (logic)");
      end
   endgenerate

   logic [AW-1:0] rom_addr;

   ucs_addr #(.OPC_W(OPC_W), .TS_W(TS_W)) u_addr (
      .flag   (flag),
      .opcode (opcode),
      .tstate (tstate),
      .addr   (rom_addr)
   );

   ucs_rom #(.OPC_W(OPC_W), .TS_W(TS_W), .CW_W(CW_W), .ROM_STYLE(ROM_STYLE)) u_rom (
      .addr (rom_addr),
      .word (ctrl_word)
   );

   ucs_tcount #(.TS_W(TS_W)) u_tc (
      .clk      (clk),
      .rst_n    (rst_n),
      .end_bit  (ctrl_word[CB_END]),
      .halt_bit (ctrl_word[CB_HALT]),
      .tstate   (tstate)
   );

   // R2: first step always drives the program counter into the address register
   a_r2_fetch_a: assert property (@(posedge clk) disable iff (!rst_n)
      (tstate == '0) |-> (ctrl_word == W_FETCH_A));

   // R2: second step always loads the instruction register
   a_r2_fetch_b: assert property (@(posedge clk) disable iff (!rst_n)
      (tstate == TS_W'(1)) |-> ((ctrl_word & W_FETCH_B) == W_FETCH_B));

   // R12: no two bus drivers at once
   a_r12_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl_word[CB_PC_DRV], ctrl_word[CB_MEM_DRV], ctrl_word[CB_IR_DRV],
                ctrl_word[CB_ALU_DRV], ctrl_word[CB_ACC_DRV]}));

   // R5: a halting word never ends the instruction
   a_r5_halt_no_end: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[CB_HALT] |-> !ctrl_word[CB_END]);
endmodule

// File: tb/sim_ucode_seq.sv
module sim_ucode_seq;
   localparam logic [15:0] PCD = 16'h0001, ADL = 16'h0002, PCS = 16'h0004, MED = 16'h0008;
   localparam logic [15:0] IRL = 16'h0010, IRD = 16'h0020, ACL = 16'h0040, OBL = 16'h0080;
   localparam logic [15:0] ALD = 16'h0100, SUBB = 16'h0200, ACD = 16'h0400, MWR = 16'h0800;
   localparam logic [15:0] PCL = 16'h1000, OUL = 16'h2000, HLT = 16'h4000, ENDB = 16'h8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  opcode = 4'h0;
   logic        flag = 1'b0;
   logic [15:0] ctrl_word;
   logic [2:0]  tstate;
   int          errors = 0;
   int          checks = 0;

   always #4 clk = ~clk;

   ucode_seq u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .flag(flag),
      .ctrl_word(ctrl_word), .tstate(tstate)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected word from the requirement text
   function automatic logic [15:0] model(input logic f, input int op, input int ts);
      logic [15:0] w;
      bit fetch_only;
      fetch_only = (op == 0) || (op >= 9 && op <= 14) || (op == 8 && f);
      if (ts == 0) return PCD | ADL;
      if (ts == 1) return PCS | MED | IRL | (fetch_only ? ENDB : 16'h0);
      w = ENDB;
      case (op)
         1: if (ts == 2) w = IRD | ADL; else if (ts == 3) w = MED | ACL | ENDB;
         2: if (ts == 2) w = IRD | ADL; else if (ts == 3) w = ACD | MWR | ENDB;
         3: if (ts == 2) w = IRD | ADL; else if (ts == 3) w = MED | OBL;
            else if (ts == 4) w = ALD | ACL | ENDB;
         4: if (ts == 2) w = IRD | ADL; else if (ts == 3) w = MED | OBL | SUBB;
            else if (ts == 4) w = ALD | SUBB | ACL | ENDB;
         5: if (ts == 2) w = IRD | ACL | ENDB;
         6: if (ts == 2) w = IRD | PCL | ENDB;
         7: if (ts == 2) w = ACD | OUL | ENDB;
         8: if (ts == 2 && !f) w = IRD | PCL | ENDB;
         15: if (ts == 2) w = HLT;
         default: w = ENDB;
      endcase
      return w;
   endfunction

   function automatic int exp_len(input logic f, input int op);
      case (op)
         0: return 2;
         1, 2: return 4;
         3, 4: return 5;
         5, 6, 7: return 3;
         8: return f ? 2 : 3;
         15: return 0;
         default: return 2;
      endcase
   endfunction

   function automatic string wtag(input logic f, input int op, input int ts);
      if (ts < 2) return "R2";
      if (f && op != 8) return "R11";
      case (op)
         3, 4: return "R7";
         1, 2, 5, 6, 7: return "R8";
         8: return "R9";
         15: return "R5";
         default: return "R10";
      endcase
   endfunction

   task automatic run_op(input logic f, input int op);
      int ts_e;
      int len;
      bit seen;
      string ttag;
      logic [15:0] w;
      @(negedge clk);
      rst_n = 1'b0; opcode = 4'(op); flag = f;
      #1;
      chk("R1 tstate", 32'(tstate), 32'd0);
      chk("R1 word", 32'(ctrl_word), 32'(PCD | ADL));
      @(negedge clk);
      rst_n = 1'b1;
      ts_e = 0; len = 0; seen = 0; ttag = "R3";
      for (int c = 0; c < 9; c++) begin
         #1;
         w = ctrl_word;
         chk(ttag, 32'(tstate), 32'(ts_e));
         chk(wtag(f, op, ts_e), 32'(w), 32'(model(f, op, ts_e)));
         chk("R12", 32'($countones({w[0], w[3], w[5], w[8], w[10]}) <= 1), 32'd1);
         if (!seen) begin
            len++;
            if (w[15]) seen = 1;
         end
         if (model(f, op, ts_e) & ENDB) begin ts_e = 0; ttag = "R4"; end
         else if (model(f, op, ts_e) & HLT) ttag = "R5";
         else begin ts_e = ts_e + 1; ttag = "R3"; end
         @(negedge clk);
      end
      chk(op == 8 ? "R9 length" : "R6 length", 32'(seen ? len : 0), 32'(exp_len(f, op)));
   endtask

   initial begin
      #(200000 * 8);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int f = 0; f < 2; f++)
         for (int op = 0; op < 16; op++)
            run_op(f[0], op);

      // R13: combinational response to opcode and flag changes mid-step
      @(negedge clk); rst_n = 1'b0; opcode = 4'h3; flag = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R13 add step3", 32'(ctrl_word), 32'(MED | OBL));
      opcode = 4'h1;
      #1;
      chk("R13 switched to load", 32'(ctrl_word), 32'(MED | ACL | ENDB));
      chk("R13 tstate kept", 32'(tstate), 32'd3);
      @(negedge clk); rst_n = 1'b0; opcode = 4'h8; flag = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R9 branch flag0", 32'(ctrl_word), 32'(IRD | PCL | ENDB));
      flag = 1'b1;
      #1;
      chk("R13 flag flips page", 32'(ctrl_word), 32'(ENDB));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule